// File: doc/BRIEF.md
# Erased-Page Zero-Bit Checker

This block runs after a page read whose error-correction result came back. It takes the 8-bit correction status of that read and a selection between the two supported correction strengths. When the status reports a correctable result, the block passes on the corrected-bit count from the status byte. When the status reports an uncorrectable result, the page may only be an erased page that has a few flipped bits. In that case the block takes the raw page as a stream of 32-bit words: the data area first, then the spare area. It counts the zero bits in each area and compares the total with half the correction strength.

A total at or under that limit raises a force-erased flag. The data path then delivers all-ones in place of the page, and the zero count is reported as the corrected-bit total. A total above the limit raises fail. Counting within an area stops once that area's count passes the limit. A stream that ends early raises an error flag. Control uses a start, busy and done handshake. Words arrive over a valid/ready interface at up to one word per clock.

Top module: `erased_page_checker`

## Requirements
- R1: A start with status bit 7 clear takes no words (word_ready_o stays low). Two clock edges after start, done_o pulses with corrected_o equal to status bits 5:0, and fail_o, force_erased_o and short_err_o are low.
- R2: A start with status bit 7 set opens the stream. The zero bits (population count of the inverted word) of the 512 data-area words and of the 16 spare-area words that follow are counted separately and then added.
- R3: The limit is half the strength: 12 when strength_sel_i is 0 (strength 24) and 16 when it is 1 (strength 32). A total equal to the limit raises force_erased_o, and one more zero bit raises fail_o.
- R4: Once an area's running count exceeds the limit, later words of that same area add nothing. Each area starts its count from zero.
- R5: When the stream completes, exactly one of fail_o (total above limit) and force_erased_o (total at or under limit) is raised, and corrected_o reports the total.
- R6: word_ready_o is high only while words are being taken. Exactly 528 words are accepted, one per clock whenever word_valid_i is high, and idle cycles on word_valid_i are tolerated.
- R7: done_o is high for a single cycle. The result outputs hold their values until the next accepted start, which clears them. busy_o is high from start until done.
- R8: word_last_i on an accepted word before the 528th ends the run with short_err_o high, fail_o and force_erased_o low, and corrected_o zero.
- R9: start_i while busy_o is high is ignored. The run in progress finishes with its own status and strength.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a check (taken only when idle) |
| ecc_status_i | input | 8 | Correction status: bit 7 uncorrectable, bits 5:0 corrected count |
| strength_sel_i | input | 1 | 0 selects strength 24, 1 selects strength 32 |
| word_valid_i | input | 1 | Stream word present |
| word_data_i | input | 32 | Raw page word |
| word_last_i | input | 1 | Final word of the stream |
| word_ready_o | output | 1 | Block takes the word this cycle |
| busy_o | output | 1 | A check is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Too many zero bits: page is not erased |
| force_erased_o | output | 1 | Treat the page as erased (substitute all-ones) |
| short_err_o | output | 1 | Stream ended before 528 words |
| corrected_o | output | 7 | Corrected-bit total |

## Verification
The case that is hardest to reach from the ports is an area count that has already passed the limit while more zero-bearing words of that area keep arriving. Only corrected_o on a failing run shows that those later words were dropped. The bench places a fully-zero word early in the data area and a half-zero word early in the spare area, with further zero bits later in both areas. The expected total is therefore the sum of the two counts frozen where they stopped, not the raw sum of all zero bits. Limit boundaries are reached by placing exactly 12 or 16 zero bits across both areas, then one more.

// File: rtl/epc_pkg.sv
// Shared types for the erased-page checker.
package epc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_DECIDE = 2'd2
    } chk_state_t;
endpackage

// File: rtl/zero_popcount.sv
// zero_popcount: combinational count of the zero bits in one stream word.
// Assumes W is small enough for a flat adder chain in one cycle.
module zero_popcount #(
    parameter int W     = 32,
    localparam int CW   = $clog2(W + 1)
) (
    input  logic [W-1:0]  word_i,
    output logic [CW-1:0] zeros_o
);
    // Purpose: add up the inverted bits of the word.
    always_comb begin
        zeros_o = '0;
        for (int b = 0; b < W; b++) begin
            zeros_o = zeros_o + CW'(!word_i[b]);
        end
    end
endmodule

// File: rtl/area_tally.sv
// area_tally: running zero count for one page area. Once the count passes the
// limit it freezes. Assumes the limit is held stable while counting.
module area_tally #(
    parameter int CNT_W = 6,
    parameter int ADD_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic [ADD_W-1:0] add_i,
    output logic [CNT_W-1:0] cnt_o
);
    // Purpose: clear on start, accumulate while at or under the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_o <= '0;
        else if (clr_i)                   cnt_o <= '0;
        else if (en_i && cnt_o <= limit_i) cnt_o <= cnt_o + CNT_W'(add_i);
    end

    assert_frozen_after_exceed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && cnt_o > limit_i) |=> $stable(cnt_o));
endmodule

// File: rtl/chk_sequencer.sv
// chk_sequencer: start/stream/decide control. Latches status and limit at
// start, counts accepted words, steers them to the data or spare tally and
// spots a stream that ends early. Assumes data words precede spare words.
module chk_sequencer
    import epc_pkg::*;
#(
    parameter int DATA_WORDS  = 512,
    parameter int SPARE_WORDS = 16,
    parameter int STRENGTH_LO = 24,
    parameter int STRENGTH_HI = 32,
    parameter int LIM_W       = 6,
    localparam int TOTAL_WORDS = DATA_WORDS + SPARE_WORDS,
    localparam int IDX_W       = $clog2(TOTAL_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [7:0]       status_i,
    input  logic             sel_i,
    input  logic             valid_i,
    input  logic             last_i,
    output logic             ready_o,
    output logic             busy_o,
    output logic             clr_o,
    output logic [1:0]       area_en_o,
    output logic             decide_o,
    output logic             unc_o,
    output logic [5:0]       status_cnt_o,
    output logic [LIM_W-1:0] limit_o,
    output logic             short_o
);
    chk_state_t       state_q;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       status_q;
    logic             beat;

    // Purpose: decode handshake and area steering from the current state.
    always_comb begin
        ready_o      = (state_q == ST_COUNT);
        busy_o       = (state_q != ST_IDLE);
        clr_o        = (state_q == ST_IDLE) && start_i;
        beat         = ready_o && valid_i;
        area_en_o[0] = beat && (idx_q <  IDX_W'(DATA_WORDS));
        area_en_o[1] = beat && (idx_q >= IDX_W'(DATA_WORDS));
        decide_o     = (state_q == ST_DECIDE);
        unc_o        = status_q[7];
        status_cnt_o = status_q[5:0];
    end

    // Purpose: state, word index, latched status, limit and short flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            idx_q    <= '0;
            status_q <= '0;
            limit_o  <= '0;
            short_o  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    status_q <= status_i;
                    limit_o  <= sel_i ? LIM_W'(STRENGTH_HI / 2) : LIM_W'(STRENGTH_LO / 2);
                    idx_q    <= '0;
                    short_o  <= 1'b0;
                    state_q  <= status_i[7] ? ST_COUNT : ST_DECIDE;
                end
                ST_COUNT: if (beat) begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == IDX_W'(TOTAL_WORDS - 1)) begin
                        state_q <= ST_DECIDE;
                    end else if (last_i) begin
                        short_o <= 1'b1;
                        state_q <= ST_DECIDE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assert_start_ignored_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !decide_o) |=> $stable(status_q));
endmodule

// File: rtl/erased_page_checker.sv
// erased_page_checker: decides whether an uncorrectable page read is really an
// erased page with a few flipped bits. Assumes the stream delivers data-area
// words then spare-area words, WORD_W bits each, and ends with word_last_i.
module erased_page_checker #(
    parameter int WORD_W      = 32,
    parameter int DATA_BYTES  = 2048,
    parameter int SPARE_BYTES = 64,
    parameter int STRENGTH_LO = 24,
    parameter int STRENGTH_HI = 32,
    localparam int DATA_WORDS  = DATA_BYTES / (WORD_W / 8),
    localparam int SPARE_WORDS = SPARE_BYTES / (WORD_W / 8),
    localparam int PC_W        = $clog2(WORD_W + 1),
    localparam int AREA_W      = $clog2(STRENGTH_HI / 2 + WORD_W + 1),
    localparam int TOT_W       = AREA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        ecc_status_i,
    input  logic              strength_sel_i,
    input  logic              word_valid_i,
    input  logic [WORD_W-1:0] word_data_i,
    input  logic              word_last_i,
    output logic              word_ready_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o,
    output logic              force_erased_o,
    output logic              short_err_o,
    output logic [TOT_W-1:0]  corrected_o
);
    logic              clr, decide, unc, short_run;
    logic [1:0]        area_en;
    logic [5:0]        status_cnt;
    logic [AREA_W-1:0] limit;
    logic [PC_W-1:0]   zeros;
    logic [AREA_W-1:0] area_cnt [2];
    logic [TOT_W-1:0]  total;

    chk_sequencer #(
        .DATA_WORDS(DATA_WORDS), .SPARE_WORDS(SPARE_WORDS),
        .STRENGTH_LO(STRENGTH_LO), .STRENGTH_HI(STRENGTH_HI), .LIM_W(AREA_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .status_i(ecc_status_i),
        .sel_i(strength_sel_i), .valid_i(word_valid_i), .last_i(word_last_i),
        .ready_o(word_ready_o), .busy_o(busy_o), .clr_o(clr), .area_en_o(area_en),
        .decide_o(decide), .unc_o(unc), .status_cnt_o(status_cnt),
        .limit_o(limit), .short_o(short_run)
    );

    zero_popcount #(.W(WORD_W)) u_pop (.word_i(word_data_i), .zeros_o(zeros));

    // One tally per area: index 0 data, index 1 spare.
    for (genvar g = 0; g < 2; g++) begin : g_area
        area_tally #(.CNT_W(AREA_W), .ADD_W(PC_W)) u_tally (
            .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_i(area_en[g]),
            .limit_i(limit), .add_i(zeros), .cnt_o(area_cnt[g])
        );
    end

    // Purpose: sum of the two area counts.
    always_comb total = TOT_W'(area_cnt[0]) + TOT_W'(area_cnt[1]);

    // Purpose: register the verdict, pulse done, clear results on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0; fail_o <= 1'b0; force_erased_o <= 1'b0;
            short_err_o <= 1'b0; corrected_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (clr) begin
                fail_o <= 1'b0; force_erased_o <= 1'b0;
                short_err_o <= 1'b0; corrected_o <= '0;
            end else if (decide) begin
                done_o <= 1'b1;
                if (!unc)                                corrected_o <= TOT_W'(status_cnt);
                else if (short_run)                      short_err_o <= 1'b1;
                else if (total > TOT_W'(limit)) begin    fail_o <= 1'b1; corrected_o <= total; end
                else begin                               force_erased_o <= 1'b1; corrected_o <= total; end
            end
        end
    end

    assert_done_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_ready_only_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready_o |-> busy_o);
    assert_verdict_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(fail_o && force_erased_o));
    assert_force_within_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        force_erased_o |-> (corrected_o <= TOT_W'(limit)));
    assert_start_enters_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
endmodule

// File: tb/erased_page_checker_test.sv
module erased_page_checker_test;
    localparam int CLK_PERIOD = 10;
    localparam int TOTAL = 528;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sel = 1'b0;
    logic [7:0] status = '0;
    logic valid = 1'b0, last = 1'b0;
    logic [31:0] data = '0;
    logic ready, busy, done, fail, force_e, short_e;
    logic [6:0] corr;
    logic [31:0] mem [TOTAL];
    int n_checks = 0, n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    erased_page_checker uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .ecc_status_i(status),
        .strength_sel_i(sel), .word_valid_i(valid), .word_data_i(data),
        .word_last_i(last), .word_ready_o(ready), .busy_o(busy), .done_o(done),
        .fail_o(fail), .force_erased_o(force_e), .short_err_o(short_e),
        .corrected_o(corr)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic fill_ones();
        for (int i = 0; i < TOTAL; i++) mem[i] = 32'hFFFF_FFFF;
    endtask

    task automatic kick(input logic [7:0] st, input logic s);
        @(negedge clk); start = 1'b1; status = st; sel = s;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic stream(input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (gaps && (i % 3 == 1)) begin valid = 1'b0; @(negedge clk); end
            valid = 1'b1; data = mem[i]; last = (i == n - 1);
            while (!ready) @(negedge clk);
        end
        @(negedge clk); valid = 1'b0; last = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        while (!done && t < 2000) begin @(negedge clk); t++; end
        check(req, "done pulse seen", int'(done), 1);
    endtask

    task automatic expect_res(input string req, input int f, input int fe, input int se, input int c);
        check(req, "fail", int'(fail), f);
        check(req, "force_erased", int'(force_e), fe);
        check(req, "short_err", int'(short_e), se);
        check(req, "corrected", int'(corr), c);
    endtask

    task automatic t_reset();
        check("R7", "reset busy", int'(busy), 0);
        check("R7", "reset done", int'(done), 0);
        check("R6", "reset ready", int'(ready), 0);
        expect_res("R7", 0, 0, 0, 0);
    endtask

    task automatic t_clean();
        kick(8'h05, 1'b0);
        check("R1", "ready low on clean", int'(ready), 0);
        check("R1", "done not yet", int'(done), 0);
        @(negedge clk);
        check("R1", "done two edges after start", int'(done), 1);
        expect_res("R1", 0, 0, 0, 5);
        @(negedge clk);
        check("R7", "done one cycle", int'(done), 0);
        repeat (4) @(negedge clk);
        check("R7", "held corrected", int'(corr), 5);
    endtask

    task automatic t_all_ones();
        fill_ones();
        kick(8'h80, 1'b0);
        check("R7", "results cleared on start", int'(corr), 0);
        check("R6", "ready while counting", int'(ready), 1);
        stream(TOTAL, 1'b0);
        wait_done("R2");
        expect_res("R2", 0, 1, 0, 0);
    endtask

    task automatic t_boundary_lo();
        fill_ones();
        mem[3] = 32'hFFFF_FF80; mem[527] = 32'hFFFF_FFE0;   // 7 + 5 = 12
        kick(8'h80, 1'b0);
        stream(TOTAL, 1'b1);
        wait_done("R3");
        expect_res("R3", 0, 1, 0, 12);
        mem[100] = 32'hFFFF_FFFE;                            // 13
        kick(8'h80, 1'b0);
        stream(TOTAL, 1'b0);
        wait_done("R5");
        expect_res("R5", 1, 0, 0, 13);
    endtask

    task automatic t_strength_hi();
        fill_ones();
        mem[0] = 32'hFFFF_0000;                              // 16
        kick(8'h80, 1'b1);
        stream(TOTAL, 1'b0);
        wait_done("R3");
        expect_res("R3", 0, 1, 0, 16);
        kick(8'h80, 1'b0);
        stream(TOTAL, 1'b0);
        wait_done("R3");
        expect_res("R3", 1, 0, 0, 16);
    endtask

    task automatic t_early_stop();
        fill_ones();
        mem[0]   = 32'h0000_0000; mem[5]   = 32'h00FF_FFFF;  // data stops at 32
        mem[512] = 32'h0000_FFFF; mem[520] = 32'hFFFF_FFF0;  // spare stops at 16
        kick(8'h80, 1'b0);
        stream(TOTAL, 1'b0);
        wait_done("R4");
        expect_res("R4", 1, 0, 0, 48);
    endtask

    task automatic t_short();
        fill_ones();
        kick(8'h80, 1'b0);
        stream(100, 1'b0);
        wait_done("R8");
        expect_res("R8", 0, 0, 1, 0);
        check("R8", "busy released", int'(busy), 0);
    endtask

    task automatic t_start_busy();
        fill_ones();
        mem[7] = 32'hFFFF_FFF8;                              // 3 zeros
        kick(8'h80, 1'b0);
        @(negedge clk); start = 1'b1; status = 8'h02; sel = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R9", "still busy", int'(busy), 1);
        stream(TOTAL, 1'b0);
        wait_done("R9");
        expect_res("R9", 0, 1, 0, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_all_ones();
        t_boundary_lo();
        t_strength_hi();
        t_early_stop();
        t_short();
        t_start_busy();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule